// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line Error Detection

This block recovers characters from an asynchronous serial line. The line passes through a two-flop synchronizer. The block then times every bit with an enable tick that runs at sixteen times the bit rate. A falling edge is accepted as a start bit only if the line is still low half a bit later. Each following bit is sampled one full bit period after the previous sample. Data bits arrive least significant first. The line configuration sets the character length and the parity rule.

Each character is delivered on a one-cycle output strobe, together with three error flags:
- **Parity error:** the received parity bit does not match the configured rule.
- **Framing error:** the single stop bit that is checked was sampled low.
- **Break:** the line stayed low for a whole character.

After a framing error, the low stop level is taken as the next start bit, so the receiver keeps reading without waiting for a new edge. A break produces exactly one all-zero character. The receiver then waits for the line to return high and for a new start bit.

The output has a valid signal but no ready signal, because a serial line cannot be held back. The consumer must take the character in the cycle where `rx_valid` is high. Nothing is held for a later cycle, so `rx_valid` is never high for two cycles in a row.

Top module: `serial_rx_os`

## Requirements
- R1: After reset `rx_valid` is 0, and no character is produced while the line stays high.
- R2: `cfg_wlen` selects 5 + `cfg_wlen` data bits (00 gives 5, 11 gives 8), received least significant bit first. `rx_data` carries them in its low bits, and its unused upper bits are 0.
- R3: With `cfg_par_en` = 1, one parity bit follows the data bits. With `cfg_stick` = 0, the expected bit is the XOR of the data bits when `cfg_even` = 1 and its inverse when `cfg_even` = 0. With `cfg_stick` = 1, the expected bit is the constant NOT `cfg_even`. `rx_perr` is 1 when the received bit differs from the expected bit, and it is always 0 when parity is disabled.
- R4: Exactly one stop bit is examined. A high stop bit gives `rx_frm` = 0, and a new frame may start right after it. A low stop bit gives `rx_frm` = 1 on that same character.
- R5: After a framing error that is not a break, the low stop level counts as a start bit that has already been qualified. The next data bit is sampled one bit period later, and the next character is delivered without any new falling edge.
- R6: A falling edge is qualified at the 8th tick. If the line is high at that point, no character is produced and the receiver returns to idle.
- R7: If the start bit, all data bits, the parity bit (when enabled) and the stop bit are all sampled low, the block delivers one character with `rx_data` = 0, `rx_brk` = 1, `rx_frm` = 1 and `rx_perr` = 0. An all-zero character whose stop bit is high is delivered as an ordinary character.
- R8: A line held low longer than one character yields only one break character. Reception resumes only after the line has gone high and a new start edge is qualified.
- R9: `rx_valid` is a single-cycle pulse. It rises one clock after the stop-bit sample, and the data and flags are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line; the idle (mark) level is 1 |
| tick_16x | input | 1 | Single-cycle enable at 16 times the bit rate |
| cfg_wlen | input | 2 | Character length code (5 + value data bits) |
| cfg_par_en | input | 1 | 1 = a parity bit follows the data bits |
| cfg_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stick | input | 1 | 1 = the parity bit is fixed at NOT cfg_even |
| rx_valid | output | 1 | One-cycle strobe: a character and its flags are present |
| rx_data | output | 8 | Received character, with unused upper bits 0 |
| rx_perr | output | 1 | Parity error for this character |
| rx_frm | output | 1 | Framing error (stop bit sampled low) for this character |
| rx_brk | output | 1 | Break detected; the character is all zeros |

## Verification
Timing of a character, counted from a falling edge on `rx_in`:
- The edge appears inside the block two clocks later.
- The start sample falls on the 8th tick after that.
- Every later sample falls 16 ticks after the previous one.
- `rx_valid` rises one clock after the stop sample, which is inside the stop bit.

The bench drives each bit for a full bit time, so every result is due before the stop bit it belongs to has ended. The bench compares the number of strobes seen against the number it expects at that point. Each strobe is read at the falling clock edge and matched, in order, against a queue of expected words that the bench computes from the requirements. A rejected start, and the tail of a long break, are checked over windows of several bit times in which the strobe count must not change.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRKW
  } rx_state_e;

  // Number of data bits selected by the 2-bit length code.
  function automatic int unsigned word_bits(input logic [1:0] code);
    return 32'd5 + 32'(code);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], rx_async};
      prev  <= chain[STAGES-1];
    end
  end

  assign line = chain[STAGES-1];
  assign fall = prev & ~line;

endmodule

// File: rtl/rx_tick_timer.sv
module rx_tick_timer #(
  parameter int OSR   = 16,
  parameter int FIRST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  output logic sample
);
  localparam int CW = $clog2(OSR);

  logic [CW-1:0] cnt;
  logic          half;

  assign sample = tick && (half ? (cnt == CW'(FIRST - 1)) : (cnt == CW'(OSR - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (arm) begin
      cnt  <= '0;
      half <= 1'b1;
    end else if (tick) begin
      if (sample) begin
        cnt  <= '0;
        half <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6
  first_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half && sample && !arm) |=> !half);

endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              even,
  input  logic              stick,
  input  logic              rx_bit,
  output logic              perr
);
  import uart_rx_pkg::*;

  logic [DATA_W-1:0] msk;
  logic              exp_bit;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign msk[g] = data[g] & (32'(g) < word_bits(wlen));
  end

  assign exp_bit = stick ? ~even : (even ? ^msk : ~^msk);
  assign perr    = par_en & (rx_bit ^ exp_bit);

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              fall,
  input  logic              sample,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              perr_in,
  output logic              arm,
  output logic [DATA_W-1:0] shreg,
  output logic              par_bit,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_frm,
  output logic              out_brk
);
  import uart_rx_pkg::*;

  localparam int IW = $clog2(DATA_W);

  rx_state_e     state;
  logic [IW-1:0] bit_idx;
  logic          zero_run;
  logic          last_bit;

  assign arm      = (state == RX_IDLE) && fall;
  assign last_bit = (bit_idx == IW'(word_bits(cfg_wlen) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      bit_idx   <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      zero_run  <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
      out_frm   <= 1'b0;
      out_brk   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (fall) state <= RX_START;
        end
        RX_START: begin
          if (sample) begin
            if (!line) begin
              state    <= RX_DATA;
              bit_idx  <= '0;
              shreg    <= '0;
              par_bit  <= 1'b0;
              zero_run <= 1'b1;
            end else begin
              state <= RX_IDLE;
            end
          end
        end
        RX_DATA: begin
          if (sample) begin
            shreg[bit_idx] <= line;
            zero_run       <= zero_run & ~line;
            if (last_bit) state <= cfg_par_en ? RX_PAR : RX_STOP;
            else          bit_idx <= bit_idx + 1'b1;
          end
        end
        RX_PAR: begin
          if (sample) begin
            par_bit  <= line;
            zero_run <= zero_run & ~line;
            state    <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (sample) begin
            out_valid <= 1'b1;
            if (line) begin
              out_data <= shreg;
              out_perr <= perr_in;
              out_frm  <= 1'b0;
              out_brk  <= 1'b0;
              state    <= RX_IDLE;
            end else if (zero_run) begin
              out_data <= '0;
              out_perr <= 1'b0;
              out_frm  <= 1'b1;
              out_brk  <= 1'b1;
              state    <= RX_BRKW;
            end else begin
              out_data <= shreg;
              out_perr <= perr_in;
              out_frm  <= 1'b1;
              out_brk  <= 1'b0;
              state    <= RX_DATA;
              bit_idx  <= '0;
              shreg    <= '0;
              par_bit  <= 1'b0;
              zero_run <= 1'b1;
            end
          end
        end
        RX_BRKW: begin
          if (line) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7
  brk_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_brk) |-> (out_frm && (out_data == '0) && !out_perr));

  // R6
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && sample && line) |=> (state == RX_IDLE && !out_valid));

  // R8
  one_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_BRKW && $past(state) == RX_BRKW) |-> !out_valid);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> word_bits(cfg_wlen)) == '0));

  // R5
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_STOP && sample && !line && !zero_run) |=> (state == RX_DATA && out_frm));

endmodule

// File: rtl/serial_rx_os.sv
module serial_rx_os #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              tick_16x,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_even,
  input  logic              cfg_stick,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_frm,
  output logic              rx_brk
);
  localparam int MID = OSR / 2;

  logic              line;
  logic              fall;
  logic              arm;
  logic              sample;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              perr;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_async (rx_in),
    .line     (line),
    .fall     (fall)
  );

  rx_tick_timer #(.OSR(OSR), .FIRST(MID)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_16x),
    .arm    (arm),
    .sample (sample)
  );

  rx_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data   (shreg),
    .wlen   (cfg_wlen),
    .par_en (cfg_par_en),
    .even   (cfg_even),
    .stick  (cfg_stick),
    .rx_bit (par_bit),
    .perr   (perr)
  );

  rx_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .line       (line),
    .fall       (fall),
    .sample     (sample),
    .cfg_wlen   (cfg_wlen),
    .cfg_par_en (cfg_par_en),
    .perr_in    (perr),
    .arm        (arm),
    .shreg      (shreg),
    .par_bit    (par_bit),
    .out_valid  (rx_valid),
    .out_data   (rx_data),
    .out_perr   (rx_perr),
    .out_frm    (rx_frm),
    .out_brk    (rx_brk)
  );

endmodule

// File: tb/serial_rx_os_tb.sv
module serial_rx_os_tb;
  localparam int BIT_CLK = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       tick_16x = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_even = 1'b0;
  logic       cfg_stick = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_perr, rx_frm, rx_brk;

  int checks = 0;
  int fails = 0;
  int out_count = 0;
  int exp_count = 0;
  bit finished = 1'b0;
  string cur_req = "R1";
  logic [10:0] exp_q[$];

  always #2 clk = ~clk;

  serial_rx_os u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick_16x(tick_16x),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
    .cfg_stick(cfg_stick), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_frm(rx_frm), .rx_brk(rx_brk)
  );

  initial forever begin
    @(negedge clk);
    tick_16x = ~tick_16x;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: every strobe against the expected queue {brk,frm,perr,data}
  initial forever begin
    @(negedge clk);
    if (rx_valid) begin
      logic [10:0] got;
      got = {rx_brk, rx_frm, rx_perr, rx_data};
      out_count++;
      if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected strobe"}, int'(got), 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(got == e, cur_req, int'(got), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  function automatic bit exp_par(input logic [7:0] d, input int pm);
    if (pm >= 3) return (pm == 3);
    if (pm == 2) return ^d;
    return ~^d;
  endfunction

  task automatic set_cfg(input int wl, input int pm);
    cfg_wlen   = 2'(wl);
    cfg_par_en = (pm != 0);
    cfg_even   = (pm == 2 || pm == 4);
    cfg_stick  = (pm >= 3);
  endtask

  task automatic drive_bit(input bit v);
    rx_in = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  // sends one frame (start optional) and queues its expected result
  task automatic send_frame(input logic [7:0] d, input int wl, input int pm,
                            input bit bad_par, input bit stop_lvl, input bit with_start);
    int nb;
    bit pb;
    nb = 5 + wl;
    pb = exp_par(d, pm) ^ bad_par;
    exp_q.push_back({1'b0, ~stop_lvl, (pm != 0) & bad_par, d});
    exp_count++;
    if (with_start) drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (pm != 0) drive_bit(pb);
    drive_bit(stop_lvl);
    chk(out_count == exp_count, {cur_req, " strobe due by end of stop bit"}, out_count, exp_count);
  endtask

  function automatic logic [7:0] pat(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      3: return 8'h5A;
      4: return 8'h01;
      default: return 8'h80;
    endcase
  endfunction

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and quiet idle line
    chk(rx_valid == 1'b0, "R1 valid low after reset", int'(rx_valid), 0);
    repeat (100) @(negedge clk);
    chk(out_count == 0, "R1 no strobe on idle line", out_count, 0);

    // R2 / R3: sweep lengths, parity modes and data patterns
    cur_req = "R2/R3 sweep";
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 5; pm++)
        for (int pi = 0; pi < 6; pi++) begin
          logic [7:0] m;
          m = 8'((9'd1 << (5 + wl)) - 1);
          set_cfg(wl, pm);
          send_frame(pat(pi) & m, wl, pm, 1'b0, 1'b1, 1'b1);
          idle_bits(1);
        end

    // R3: wrong parity bit in every parity mode
    cur_req = "R3 bad parity";
    for (int pm = 1; pm < 5; pm++) begin
      set_cfg(3, pm);
      send_frame(8'h3C, 3, pm, 1'b1, 1'b1, 1'b1);
      idle_bits(1);
    end

    // R4: one stop bit only, frames back to back
    cur_req = "R4 single stop bit";
    set_cfg(1, 2);
    send_frame(8'h2B, 1, 2, 1'b0, 1'b1, 1'b1);
    send_frame(8'h14, 1, 2, 1'b0, 1'b1, 1'b1);
    idle_bits(1);

    // R4/R5: framing error, then resync on the low stop level
    cur_req = "R5 framing resync";
    set_cfg(3, 0);
    send_frame(8'h81, 3, 0, 1'b0, 1'b0, 1'b1);
    send_frame(8'h42, 3, 0, 1'b0, 1'b1, 1'b0);
    idle_bits(1);
    set_cfg(2, 1);
    send_frame(8'h33, 2, 1, 1'b0, 1'b0, 1'b1);
    send_frame(8'h4C, 2, 1, 1'b0, 1'b1, 1'b0);
    idle_bits(1);

    // R7 boundary: zero data, high parity, low stop is a framing error only;
    // the resynced character then reads an idle line: 0xFF, odd parity ok
    cur_req = "R7 zero data not break";
    set_cfg(3, 1);
    send_frame(8'h00, 3, 1, 1'b0, 1'b0, 1'b1);
    exp_q.push_back({3'b000, 8'hFF});
    exp_count++;
    idle_bits(11);
    chk(out_count == exp_count, "R5 resync char from idle line", out_count, exp_count);
    set_cfg(3, 2);
    send_frame(8'h00, 3, 2, 1'b0, 1'b1, 1'b1);
    idle_bits(1);

    // R6: short low glitches are rejected
    cur_req = "R6 false start";
    set_cfg(3, 0);
    rx_in = 1'b0;
    repeat (12) @(negedge clk);
    rx_in = 1'b1;
    idle_bits(3);
    chk(out_count == exp_count, "R6 no strobe after glitch", out_count, exp_count);
    set_cfg(0, 3);
    rx_in = 1'b0;
    repeat (6) @(negedge clk);
    rx_in = 1'b1;
    idle_bits(3);
    chk(out_count == exp_count, "R6 no strobe after short glitch", out_count, exp_count);
    send_frame(8'h15, 0, 3, 1'b0, 1'b1, 1'b1);
    idle_bits(1);

    // R7/R8: long break, one character, then resume
    cur_req = "R7 break";
    set_cfg(3, 2);
    exp_q.push_back({3'b110, 8'h00});
    exp_count++;
    for (int i = 0; i < 25; i++) drive_bit(1'b0);
    chk(out_count == exp_count, "R8 one break char for long low", out_count, exp_count);
    idle_bits(2);
    cur_req = "R8 resume after break";
    send_frame(8'h55, 3, 2, 1'b0, 1'b1, 1'b1);
    idle_bits(1);

    // R8: two breaks separated by a short mark
    cur_req = "R8 repeated break";
    set_cfg(0, 0);
    exp_q.push_back({3'b110, 8'h00});
    exp_q.push_back({3'b110, 8'h00});
    exp_count += 2;
    for (int i = 0; i < 9; i++) drive_bit(1'b0);
    drive_bit(1'b1);
    for (int i = 0; i < 9; i++) drive_bit(1'b0);
    chk(out_count == exp_count, "R8 one char per break", out_count, exp_count);
    idle_bits(2);
    send_frame(8'h1E, 0, 0, 1'b0, 1'b1, 1'b1);
    idle_bits(2);

    cur_req = "R9";
    chk(exp_q.size() == 0, "R9 all expected strobes seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule